// File: doc/BRIEF.md
# Buffered Serial Peripheral Target

This block is the target (slave) end of a four-wire synchronous serial link. An external controller supplies the serial clock and the active-low select. The block takes data in on `mosiIn` and drives data out on `misoOut`. On the host side there is a plain register-style port. A write strobe parks the next outgoing word in a transmit holding register. A read port shows the last complete incoming word, and a read strobe acknowledges it.

Run-time configuration inputs set four things:
- the frame length (8 or 16 bits),
- the idle level of the serial clock,
- whether data is captured on the first or the second clock edge of each bit,
- whether the low or the high bit travels first.

Select can come from the `selNIn` pin. It can also come from a software level that replaces the pin altogether.

The serial clock, data and select inputs are synchronized into the system clock domain, and serial edges are found there. The system clock must therefore run at least four times faster than the serial clock. Two status flags report the state of the holding registers: transmit-empty and receive-full. Each flag has an interrupt output gated by its own enable.

Top module: `sspi_target`

## Requirements
- R1: After reset, `txEmpty` is 1, `rxFull` is 0, both interrupt outputs are 0 and `misoOut` is 0.
- R2: In 8-bit mode (`cfgWide`=0), a frame moves 8 bits. `rdData` then holds the received byte in bits 7:0 with bits 15:8 zero. The low byte of the transmit word is what goes out.
- R3: In 16-bit mode (`cfgWide`=1), a frame moves 16 bits in both directions, using the full `wrData`/`rdData` width.
- R4: `cfgLsbFirst`=1 sends and captures bit 0 first. With `cfgLsbFirst`=0, the top bit of the frame (bit 7 or bit 15) goes first.
- R5: The serial clock idles at the level `cfgPol`. With `cfgPha`=0, each bit is captured on the first clock transition away from idle, and the next output bit appears on the return transition. With `cfgPha`=1, the output bit appears on the first transition and is captured on the return. All four combinations work.
- R6: A host write (`wrEn`) clears `txEmpty`. When a frame starts, the held word moves into the shift register and `txEmpty` becomes 1.
- R7: After the last capture edge of a frame, the received word appears on `rdData` and `rxFull` becomes 1. A `rdEn` pulse clears `rxFull`. `rdData` changes only when a frame completes.
- R8: `irqTx` is 1 exactly when `ieTxEmpty` and `txEmpty` are both 1. `irqRx` is 1 exactly when `ieRxFull` and `rxFull` are both 1.
- R9: With `cfgSwSel`=1, the `selNIn` pin is ignored and the block is selected only while `cfgSwSelLvl` is 0.
- R10: `misoOut` is 0 whenever the block is not selected.
- R11: If a frame starts while `txEmpty` is 1, the previously transmitted word is sent again.
- R12: Releasing select before a frame ends abandons the frame. `rxFull` and `rdData` stay unchanged, and the next frame starts from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclkIn | input | 1 | Serial clock from the controller |
| mosiIn | input | 1 | Serial data in |
| selNIn | input | 1 | Active-low select pin |
| misoOut | output | 1 | Serial data out |
| cfgWide | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| cfgPol | input | 1 | Idle level of the serial clock |
| cfgPha | input | 1 | 0 = capture on first edge, 1 = capture on second edge |
| cfgLsbFirst | input | 1 | 1 = bit 0 first |
| cfgSwSel | input | 1 | 1 = use the software select level instead of the pin |
| cfgSwSelLvl | input | 1 | Software select level, active low |
| ieTxEmpty | input | 1 | Interrupt enable for transmit-empty |
| ieRxFull | input | 1 | Interrupt enable for receive-full |
| wrEn | input | 1 | Host write strobe for the transmit holding register |
| wrData | input | 16 | Host write data |
| rdEn | input | 1 | Host read acknowledge, clears receive-full |
| rdData | output | 16 | Last received word |
| txEmpty | output | 1 | Transmit holding register is free |
| rxFull | output | 1 | Unread received word available |
| irqTx | output | 1 | Transmit-empty interrupt |
| irqRx | output | 1 | Receive-full interrupt |

## Verification
The embedded properties make two assumptions:
- the configuration inputs change only while the block is deselected, so the bit counter never sees its frame length shrink in mid-frame;
- each serial clock half-period spans several system clocks, so the synchronizers never merge two edges.

The bench keeps within both. It changes mode and polarity only with select released, and it parks the serial clock at its new idle level before selecting. It holds each serial half-period for four system clocks. All stimulus changes on the falling system clock edge.

// File: rtl/sspi_pkg.sv
package sspi_pkg;
  localparam int WORD_W   = 16;
  localparam int NARROW_W = 8;
  localparam int IDX_W    = $clog2(WORD_W);
  localparam int LEN_W    = IDX_W + 1;

  // strobes from control to datapath, one system clock wide
  typedef struct packed {
    logic             selected;
    logic             load;     // frame start: holding word -> shift register
    logic             sample;   // capture mosi at pos
    logic             launch;   // present shift register bit at pos
    logic             commit;   // last capture of the frame
    logic [IDX_W-1:0] pos;
    logic             mosi;
  } strobe_t;
endpackage

// File: rtl/sspi_ctrl.sv
module sspi_ctrl
  import sspi_pkg::*;
#(
  parameter int SYNC_LEN = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclkIn,
  input  logic    mosiIn,
  input  logic    selNIn,
  input  logic    cfgWide,
  input  logic    cfgPol,
  input  logic    cfgPha,
  input  logic    cfgLsbFirst,
  input  logic    cfgSwSel,
  input  logic    cfgSwSelLvl,
  output strobe_t st
);
  logic [SYNC_LEN-1:0] sclkQ, mosiQ, selQ;
  logic sclkD;
  logic [IDX_W-1:0] bitCnt;
  logic loaded;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ <= '0;
      mosiQ <= '0;
      selQ  <= '1;
      sclkD <= 1'b0;
    end else begin
      sclkQ <= {sclkQ[SYNC_LEN-2:0], sclkIn};
      mosiQ <= {mosiQ[SYNC_LEN-2:0], mosiIn};
      selQ  <= {selQ[SYNC_LEN-2:0], selNIn};
      sclkD <= sclkQ[SYNC_LEN-1];
    end
  end

  logic sclkS, riseE, fallE, leadE, trailE, capE, outE, selected, last;
  logic [LEN_W-1:0] nBits, revPos;

  assign sclkS    = sclkQ[SYNC_LEN-1];
  assign riseE    = sclkS & ~sclkD;
  assign fallE    = ~sclkS & sclkD;
  assign leadE    = cfgPol ? fallE : riseE;
  assign trailE   = cfgPol ? riseE : fallE;
  assign capE     = cfgPha ? trailE : leadE;
  assign outE     = cfgPha ? leadE : trailE;
  assign selected = cfgSwSel ? ~cfgSwSelLvl : ~selQ[SYNC_LEN-1];
  assign nBits    = cfgWide ? LEN_W'(WORD_W) : LEN_W'(NARROW_W);
  assign last     = ({1'b0, bitCnt} == (nBits - LEN_W'(1)));
  assign revPos   = nBits - LEN_W'(1) - {1'b0, bitCnt};

  always_comb begin
    st.selected = selected;
    st.load     = selected & ~loaded;
    st.sample   = selected & loaded & capE;
    st.launch   = selected & loaded & outE & (bitCnt != '0);
    st.commit   = selected & loaded & capE & last;
    st.pos      = cfgLsbFirst ? bitCnt : revPos[IDX_W-1:0];
    st.mosi     = mosiQ[SYNC_LEN-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      loaded <= 1'b0;
    end else if (!selected) begin
      bitCnt <= '0;
      loaded <= 1'b0;
    end else begin
      if (st.load) loaded <= 1'b1;
      if (st.sample) begin
        bitCnt <= last ? '0 : bitCnt + IDX_W'(1);
        if (last) loaded <= 1'b0;
      end
    end
  end

  // R3 / R2: counter never leaves the configured frame
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    selected |-> ({1'b0, bitCnt} < nBits));
  // R12: losing select mid-frame restarts the count
  p_abort_restart_r12: assert property (@(posedge clk) disable iff (!rstN)
    (loaded && !selected) |=> (bitCnt == '0) && !loaded);
endmodule

// File: rtl/sspi_dpath.sv
module sspi_dpath
  import sspi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           st,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              misoOut,
  output logic              txEmpty,
  output logic              rxFull
);
  logic [WORD_W-1:0] txBuf, txSh, rxSh, rxBuf, txWord, rxNext;
  logic misoBit;

  // empty holding register: resend what the shift register last held (R11)
  assign txWord = txEmpty ? txSh : txBuf;

  always_comb begin
    rxNext         = rxSh;
    rxNext[st.pos] = st.mosi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBuf   <= '0;
      txSh    <= '0;
      rxSh    <= '0;
      rxBuf   <= '0;
      txEmpty <= 1'b1;
      rxFull  <= 1'b0;
      misoBit <= 1'b0;
    end else begin
      if (st.load) begin
        txSh    <= txWord;
        misoBit <= txWord[st.pos];
        rxSh    <= '0;
        txEmpty <= 1'b1;
      end else if (st.launch) begin
        misoBit <= txSh[st.pos];
      end
      if (st.sample) rxSh <= rxNext;
      if (wrEn) begin
        txBuf   <= wrData;
        txEmpty <= 1'b0;
      end
      if (st.commit) begin
        rxBuf  <= rxNext;
        rxFull <= 1'b1;
      end else if (rdEn) begin
        rxFull <= 1'b0;
      end
    end
  end

  assign rdData  = rxBuf;
  assign misoOut = st.selected & misoBit;

  p_rx_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    st.commit |=> rxFull);
  p_rd_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !st.commit) |=> !rxFull);
  p_rx_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !st.commit |=> $stable(rdData));
  p_tx_take_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.load && !wrEn) |=> txEmpty);
  p_tx_fill_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> !txEmpty);
endmodule

// File: rtl/sspi_target.sv
module sspi_target
  import sspi_pkg::*;
#(
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclkIn,
  input  logic              mosiIn,
  input  logic              selNIn,
  output logic              misoOut,
  input  logic              cfgWide,
  input  logic              cfgPol,
  input  logic              cfgPha,
  input  logic              cfgLsbFirst,
  input  logic              cfgSwSel,
  input  logic              cfgSwSelLvl,
  input  logic              ieTxEmpty,
  input  logic              ieRxFull,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  output logic [WORD_W-1:0] rdData,
  output logic              txEmpty,
  output logic              rxFull,
  output logic              irqTx,
  output logic              irqRx
);
  strobe_t st;

  sspi_ctrl #(.SYNC_LEN(SYNC_LEN)) uCtrl (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .mosiIn(mosiIn), .selNIn(selNIn),
    .cfgWide(cfgWide), .cfgPol(cfgPol), .cfgPha(cfgPha),
    .cfgLsbFirst(cfgLsbFirst), .cfgSwSel(cfgSwSel), .cfgSwSelLvl(cfgSwSelLvl),
    .st(st)
  );

  sspi_dpath uDpath (
    .clk(clk), .rstN(rstN), .st(st), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .misoOut(misoOut),
    .txEmpty(txEmpty), .rxFull(rxFull)
  );

  assign irqTx = ieTxEmpty & txEmpty;
  assign irqRx = ieRxFull & rxFull;
endmodule

// File: tb/sim_sspi_target.sv
module sim_sspi_target;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclkIn = 1'b0, mosiIn = 1'b0, selNIn = 1'b1;
  logic cfgWide = 1'b0, cfgPol = 1'b0, cfgPha = 1'b0, cfgLsbFirst = 1'b0;
  logic cfgSwSel = 1'b0, cfgSwSelLvl = 1'b1, ieTxEmpty = 1'b0, ieRxFull = 1'b0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic misoOut, txEmpty, rxFull, irqTx, irqRx;
  int nChk = 0, nFail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sspi_target u0 (
    .clk(clk), .rstN(rstN), .sclkIn(sclkIn), .mosiIn(mosiIn), .selNIn(selNIn),
    .misoOut(misoOut), .cfgWide(cfgWide), .cfgPol(cfgPol), .cfgPha(cfgPha),
    .cfgLsbFirst(cfgLsbFirst), .cfgSwSel(cfgSwSel), .cfgSwSelLvl(cfgSwSelLvl),
    .ieTxEmpty(ieTxEmpty), .ieRxFull(ieRxFull), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .txEmpty(txEmpty), .rxFull(rxFull),
    .irqTx(irqTx), .irqRx(irqRx)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic hostWrite(input logic [15:0] w);
    @(negedge clk); wrEn = 1'b1; wrData = w;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic hostRead(output logic [15:0] w);
    @(negedge clk); w = rdData; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  // controller-side bit engine; nClk < nFrame gives a cut-short frame
  task automatic runBits(input logic [15:0] txw, input int nFrame, input int nClk,
                         output logic [15:0] rxw);
    rxw = '0;
    for (int i = 0; i < nClk; i++) begin
      int p = cfgLsbFirst ? i : nFrame - 1 - i;
      if (!cfgPha) begin
        mosiIn = txw[p]; idle(4);
        sclkIn = ~cfgPol; rxw[p] = misoOut; idle(4);
        sclkIn = cfgPol;
      end else begin
        sclkIn = ~cfgPol; mosiIn = txw[p]; idle(4);
        sclkIn = cfgPol; rxw[p] = misoOut; idle(4);
      end
    end
  endtask

  task automatic selectOn();
    sclkIn = cfgPol; idle(6);
    if (cfgSwSel) cfgSwSelLvl = 1'b0; else selNIn = 1'b0;
    idle(6);
  endtask

  task automatic selectOff();
    idle(4);
    if (cfgSwSel) cfgSwSelLvl = 1'b1; else selNIn = 1'b1;
    idle(6);
  endtask

  task automatic xfer(input logic [15:0] txw, output logic [15:0] rxw);
    selectOn();
    runBits(txw, cfgWide ? 16 : 8, cfgWide ? 16 : 8, rxw);
    selectOff();
  endtask

  task automatic t_reset();
    chk("R1 txEmpty", 16'(txEmpty), 16'd1);
    chk("R1 rxFull", 16'(rxFull), 16'd0);
    chk("R1 irqTx", 16'(irqTx), 16'd0);
    chk("R1 irqRx", 16'(irqRx), 16'd0);
    chk("R10 misoOut idle", 16'(misoOut), 16'd0);
  endtask

  task automatic t_basic();
    logic [15:0] got, rd;
    cfgWide = 0; cfgPol = 0; cfgPha = 0; cfgLsbFirst = 0;
    hostWrite(16'h12A5);
    chk("R6 write clears txEmpty", 16'(txEmpty), 16'd0);
    xfer(16'h003C, got);
    chk("R2 byte out", got, 16'h00A5);
    chk("R6 txEmpty after start", 16'(txEmpty), 16'd1);
    chk("R7 rxFull set", 16'(rxFull), 16'd1);
    chk("R10 misoOut after frame", 16'(misoOut), 16'd0);
    hostRead(rd);
    chk("R2 byte in", rd, 16'h003C);
    chk("R7 read clears", 16'(rxFull), 16'd0);
  endtask

  task automatic t_wide();
    logic [15:0] got, rd;
    cfgWide = 1;
    hostWrite(16'hBEEF);
    xfer(16'h1234, got);
    chk("R3 word out", got, 16'hBEEF);
    hostRead(rd);
    chk("R3 word in", rd, 16'h1234);
    cfgLsbFirst = 1;
    hostWrite(16'h8001);
    xfer(16'hC003, got);
    chk("R4 wide lsb out", got, 16'h8001);
    hostRead(rd);
    chk("R4 wide lsb in", rd, 16'hC003);
    cfgWide = 0; cfgLsbFirst = 0;
  endtask

  task automatic t_lsb();
    logic [15:0] got, rd;
    cfgLsbFirst = 1;
    hostWrite(16'h000E);
    xfer(16'h00C1, got);
    chk("R4 lsb out", got, 16'h000E);
    hostRead(rd);
    chk("R4 lsb in", rd, 16'h00C1);
    cfgLsbFirst = 0;
  endtask

  task automatic t_modes();
    logic [15:0] got, rd;
    for (int m = 0; m < 4; m++) begin
      logic [15:0] outW = 16'(8'h31 + 8'(m * 37));
      logic [15:0] inW  = 16'(8'hC6 - 8'(m * 29));
      cfgPol = m[1]; cfgPha = m[0];
      hostWrite(outW);
      xfer(inW, got);
      chk($sformatf("R5 mode %0d out", m), got, outW);
      hostRead(rd);
      chk($sformatf("R5 mode %0d in", m), rd, inW);
    end
    cfgPol = 0; cfgPha = 0;
  endtask

  task automatic t_irq();
    logic [15:0] got, rd;
    ieTxEmpty = 1; @(negedge clk);
    chk("R8 irqTx on", 16'(irqTx), 16'd1);
    ieTxEmpty = 0; @(negedge clk);
    chk("R8 irqTx masked", 16'(irqTx), 16'd0);
    ieTxEmpty = 1; hostWrite(16'h0055);
    chk("R8 irqTx after write", 16'(irqTx), 16'd0);
    ieRxFull = 1; @(negedge clk);
    chk("R8 irqRx idle", 16'(irqRx), 16'd0);
    xfer(16'h00AA, got);
    chk("R8 irqRx on", 16'(irqRx), 16'd1);
    chk("R8 irqTx after start", 16'(irqTx), 16'd1);
    ieRxFull = 0; @(negedge clk);
    chk("R8 irqRx masked", 16'(irqRx), 16'd0);
    hostRead(rd);
    ieTxEmpty = 0;
  endtask

  task automatic t_swsel();
    logic [15:0] got, rd;
    hostWrite(16'h0042);
    cfgSwSel = 1; cfgSwSelLvl = 1;
    sclkIn = cfgPol; idle(6);
    selNIn = 0; idle(6);
    runBits(16'h0033, 8, 8, got);
    idle(6);
    chk("R9 pin ignored rxFull", 16'(rxFull), 16'd0);
    chk("R10 miso held low", got, 16'h0000);
    chk("R9 word kept", 16'(txEmpty), 16'd0);
    selNIn = 1; idle(6);
    xfer(16'h006D, got);
    chk("R9 sw select out", got, 16'h0042);
    hostRead(rd);
    chk("R9 sw select in", rd, 16'h006D);
    cfgSwSel = 0; cfgSwSelLvl = 1;
  endtask

  task automatic t_repeat();
    logic [15:0] got, rd;
    hostWrite(16'h005A);
    xfer(16'h0001, got);
    chk("R11 first send", got, 16'h005A);
    hostRead(rd);
    xfer(16'h0002, got);
    chk("R11 resend", got, 16'h005A);
    hostRead(rd);
    chk("R11 rx still works", rd, 16'h0002);
  endtask

  task automatic t_abort();
    logic [15:0] got, rd;
    hostWrite(16'h0077);
    selectOn();
    runBits(16'h00F0, 8, 3, got);
    selectOff();
    chk("R12 no commit", 16'(rxFull), 16'd0);
    chk("R12 rdData kept", rdData, 16'h0002);
    xfer(16'h0099, got);
    chk("R12 next frame aligned out", got, 16'h0077);
    chk("R12 next frame commits", 16'(rxFull), 16'd1);
    hostRead(rd);
    chk("R12 next frame aligned in", rd, 16'h0099);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(4);
    t_reset();
    t_basic();
    t_wide();
    t_lsb();
    t_modes();
    t_irq();
    t_swsel();
    t_repeat();
    t_abort();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    nChk++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule